// File: doc/BRIEF.md
# Aligned Fetch-Group Issue Stage

This block sits between instruction fetch and the execution units of a four-wide in-order core. Fetch hands it a group of four 32-bit instruction lanes together with the group's byte address and a per-lane valid mask. The stage holds that group and, each cycle, issues as many of its remaining lanes as a separate dependency checker marks ready. Order is strict: lanes issue in program order, so a lane that cannot go holds back every younger lane of the same group.

Lanes keep their positions. Nothing is shifted between lanes and nothing from a later group fills an empty lane. The next group enters only after every valid lane of the current one has issued, or after a flush throws the rest away. A group whose address does not sit on a 16-byte boundary is refused and flagged. Invalid lanes, such as padding, are treated as already issued.

Top module: `fetch_group_issue`

## Requirements
- R1: After reset `grp_ready` is 1, `issue_mask` is 0 and `misalign_err` is 0, including a reset applied while a group is still pending.
- R2: When `grp_valid` and `grp_ready` are both 1 and the low 4 bits of `grp_addr` are zero, the group is loaded; its lanes can issue from the next cycle on, never in the loading cycle.
- R3: Bit i of `issue_mask` (bit 0 is the oldest lane) is 1 only if lane i is pending, `slot_ready[i]` is 1, and every older pending lane also issues in that cycle; all four lanes can issue in one cycle.
- R4: Each valid lane of a loaded group issues exactly once; a lane that has issued never appears in `issue_mask` again.
- R5: A lane whose `grp_slot_valid` bit was 0 at load never issues and does not hold back younger lanes.
- R6: `grp_ready` is 1 exactly when no lane of the current group remains to issue.
- R7: A group offered while `grp_ready` is 1 with a nonzero low 4 address bits is refused: `misalign_err` is 1 in that cycle, nothing is loaded and `grp_ready` stays 1.
- R8: When `flush` is 1 and no group is being loaded, `issue_mask` is 0 in that cycle and all remaining lanes are discarded, so `grp_ready` is 1 in the next cycle; a group loaded in a cycle with `flush` high is kept.
- R9: Lane i of `issue_insns` always carries lane i of the loaded group's instruction word (bits 32*i+31 down to 32*i).
- R10: A group loaded with all valid bits 0 issues nothing and leaves `grp_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A fetch group is offered |
| grp_ready | output | 1 | No lane remains to issue; a group may be taken |
| grp_addr | input | 32 | Byte address of the offered group |
| grp_insns | input | 128 | Four instruction words, lane 0 in the low bits |
| grp_slot_valid | input | 4 | Per-lane valid mask of the offered group |
| slot_ready | input | 4 | Per-lane ready from the dependency checker |
| flush | input | 1 | Discard the rest of the current group |
| issue_mask | output | 4 | Lanes issuing in this cycle |
| issue_insns | output | 128 | Instruction words of the held group |
| misalign_err | output | 1 | Offered group refused for bad alignment |

## Verification
A corrupted issued bitmask shows at the ports within one cycle: a lane that issues twice or never, or a `grp_ready` that rises while a lane is still pending or stays low after the last one. A wrong order chain appears in the same cycle as a younger lane in `issue_mask` above a blocked older lane. A bad alignment or flush decision shows one cycle later as a group that did or did not load, seen in `grp_ready` and the following issue pattern.

// File: rtl/fgi_pkg.sv
package fgi_pkg;
  localparam int unsigned FGI_SLOTS  = 4;
  localparam int unsigned FGI_INSN_W = 32;
  localparam int unsigned FGI_ADDR_W = 32;
  localparam int unsigned FGI_GRP_BYTES = FGI_SLOTS * FGI_INSN_W / 8;
  localparam int unsigned FGI_ALIGN_BITS = $clog2(FGI_GRP_BYTES);

  typedef logic [FGI_SLOTS-1:0] slot_mask_t;

  // Low address bits must all be zero for a group to be accepted.
  function automatic logic addr_aligned(input logic [FGI_ADDR_W-1:0] a);
    return (a[FGI_ALIGN_BITS-1:0] == '0);
  endfunction

  // Lanes still owed by the held group.
  function automatic slot_mask_t lanes_left(input slot_mask_t vmask,
                                            input slot_mask_t done);
    return vmask & ~done;
  endfunction
endpackage

// File: rtl/fgi_align_chk.sv
module fgi_align_chk
  import fgi_pkg::*;
(
  input  logic [FGI_ADDR_W-1:0] addr,
  output logic                  aligned
);
  assign aligned = addr_aligned(addr);
endmodule

// File: rtl/fgi_slot_pick.sv
module fgi_slot_pick
  import fgi_pkg::*;
(
  input  slot_mask_t pending,
  input  slot_mask_t slot_ready,
  input  logic       flush,
  output slot_mask_t grant
);
  logic [FGI_SLOTS:0] stall_chain;

  assign stall_chain[0] = flush;

  for (genvar i = 0; i < FGI_SLOTS; i++) begin : g_lane
    assign grant[i] = pending[i] & slot_ready[i] & ~stall_chain[i];
    assign stall_chain[i+1] = stall_chain[i] | (pending[i] & ~slot_ready[i]);
  end
endmodule

// File: rtl/fgi_group_state.sv
module fgi_group_state
  import fgi_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic                            flush,
  input  logic [FGI_SLOTS*FGI_INSN_W-1:0] new_insns,
  input  slot_mask_t                      new_valid,
  input  slot_mask_t                      grant,
  output slot_mask_t                      pending,
  output logic [FGI_SLOTS*FGI_INSN_W-1:0] held_insns
);
  slot_mask_t vmask_q;
  slot_mask_t done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmask_q    <= '0;
      done_q     <= '0;
      held_insns <= '0;
    end else if (load) begin
      vmask_q    <= new_valid;
      done_q     <= '0;
      held_insns <= new_insns;
    end else if (flush) begin
      done_q     <= '1;
    end else begin
      done_q     <= done_q | grant;
    end
  end

  assign pending = lanes_left(vmask_q, done_q);
endmodule

// File: rtl/fetch_group_issue.sv
module fetch_group_issue
  import fgi_pkg::*;
#(
  parameter int unsigned INSN_W = FGI_INSN_W,
  parameter int unsigned ADDR_W = FGI_ADDR_W,
  parameter int unsigned SLOTS  = FGI_SLOTS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grp_valid,
  output logic                    grp_ready,
  input  logic [ADDR_W-1:0]       grp_addr,
  input  logic [SLOTS*INSN_W-1:0] grp_insns,
  input  logic [SLOTS-1:0]        grp_slot_valid,
  input  logic [SLOTS-1:0]        slot_ready,
  input  logic                    flush,
  output logic [SLOTS-1:0]        issue_mask,
  output logic [SLOTS*INSN_W-1:0] issue_insns,
  output logic                    misalign_err
);
  slot_mask_t pending_w;
  logic       aligned_w;
  logic       accept_w;

  fgi_align_chk u_align (
    .addr    (grp_addr),
    .aligned (aligned_w)
  );

  fgi_slot_pick u_pick (
    .pending    (pending_w),
    .slot_ready (slot_ready),
    .flush      (flush),
    .grant      (issue_mask)
  );

  fgi_group_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_w),
    .flush      (flush),
    .new_insns  (grp_insns),
    .new_valid  (grp_slot_valid),
    .grant      (issue_mask),
    .pending    (pending_w),
    .held_insns (issue_insns)
  );

  assign grp_ready    = (pending_w == '0);
  assign accept_w     = grp_valid & grp_ready & aligned_w;
  assign misalign_err = grp_valid & grp_ready & ~aligned_w;
endmodule

// File: rtl/fgi_checker.sv
module fgi_checker
  import fgi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       grp_ready,
  input slot_mask_t grp_slot_valid,
  input logic       flush,
  input slot_mask_t issue_mask,
  input logic       misalign_err,
  input slot_mask_t pending,
  input logic       accept
);
  slot_mask_t stuck;
  assign stuck = pending & ~issue_mask;

  AST_NO_YOUNGER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck != '0) |-> (issue_mask < (stuck & (~stuck + 1'b1)))); // R3
  AST_ISSUE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & ~pending) == '0); // R5
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask != '0 && !accept) |=> ((pending & $past(issue_mask)) == '0)); // R4
  AST_LOAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pending == $past(grp_slot_valid))); // R2
  AST_LOAD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (issue_mask == '0)); // R2
  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |=> (pending == '0)); // R7
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !accept) |-> (issue_mask == '0)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !accept) |=> grp_ready); // R8
endmodule

bind fetch_group_issue fgi_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .grp_ready      (grp_ready),
  .grp_slot_valid (grp_slot_valid),
  .flush          (flush),
  .issue_mask     (issue_mask),
  .misalign_err   (misalign_err),
  .pending        (pending_w),
  .accept         (accept_w)
);

// File: tb/sim_fetch_group_issue.sv
module sim_fetch_group_issue;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 20;
  // fields: gv(1) addr_lo(4) slot_valid(4) slot_ready(4) flush(1) exp_issue(4) exp_ready(1) exp_err(1)
  localparam logic [19:0] TBL [NSTEP] = '{
    {1'b1, 4'h0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h5, 1'b0, 4'h1, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hC, 1'b0, 4'h0, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hE, 1'b0, 4'hE, 1'b0, 1'b0},
    {1'b1, 4'h0, 4'h5, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 4'h5, 1'b0, 1'b0},
    {1'b1, 4'h4, 4'hF, 4'hF, 1'b0, 4'h0, 1'b1, 1'b1},
    {1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b1, 4'h0, 4'hA, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h2, 1'b0, 4'h2, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h8, 1'b1, 4'h0, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b1, 4'h0, 4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b1, 4'h0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 4'hF, 1'b0, 1'b0},
    {1'b1, 4'h8, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1},
    {1'b1, 4'h0, 4'h1, 4'h0, 1'b1, 4'h0, 1'b1, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h1, 1'b0, 4'h1, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         grp_valid = 1'b0;
  logic         grp_ready;
  logic [31:0]  grp_addr = '0;
  logic [127:0] grp_insns = '0;
  logic [3:0]   grp_slot_valid = '0;
  logic [3:0]   slot_ready = '0;
  logic         flush = 1'b0;
  logic [3:0]   issue_mask;
  logic [127:0] issue_insns;
  logic         misalign_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  fetch_group_issue u0 (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_addr(grp_addr), .grp_insns(grp_insns), .grp_slot_valid(grp_slot_valid),
    .slot_ready(slot_ready), .flush(flush), .issue_mask(issue_mask),
    .issue_insns(issue_insns), .misalign_err(misalign_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<5000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic gv, input logic [31:0] a, input logic [3:0] sv,
                       input logic [3:0] sr, input logic fl);
    grp_valid = gv; grp_addr = a; grp_slot_valid = sv; slot_ready = sr; flush = fl;
  endtask

  initial begin
    logic [127:0] lanes;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(grp_ready === 1'b1, "R1 ready after reset", 128'(grp_ready), 128'd1);
    chk(issue_mask === 4'h0 && misalign_err === 1'b0, "R1 idle outputs",
        128'({issue_mask, misalign_err}), 128'd0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int s = 0; s < NSTEP; s++) begin
      @(posedge clk); #1;
      drive(TBL[s][19], {16'h4000, 12'(s), TBL[s][18:15]}, TBL[s][14:11],
            TBL[s][10:7], TBL[s][6]);
      @(negedge clk);
      chk(issue_mask === TBL[s][5:2], $sformatf("R3 step %0d issue", s),
          128'(issue_mask), 128'(TBL[s][5:2]));
      chk(grp_ready === TBL[s][1], $sformatf("R6 step %0d ready", s),
          128'(grp_ready), 128'(TBL[s][1]));
      chk(misalign_err === TBL[s][0], $sformatf("R7 step %0d err", s),
          128'(misalign_err), 128'(TBL[s][0]));
    end

    // R9: lanes keep their positions
    for (int i = 0; i < 4; i++) lanes[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 17);
    @(posedge clk); #1;
    grp_insns = lanes;
    drive(1'b1, 32'h1000_0010, 4'hF, 4'h0, 1'b0);
    @(negedge clk);
    chk(grp_ready === 1'b1 && issue_mask === 4'h0, "R2 load cycle silent",
        128'({grp_ready, issue_mask}), 128'h10);
    @(posedge clk); #1;
    grp_insns = '0;
    drive(1'b0, 32'h0, 4'h0, 4'h3, 1'b0);
    @(negedge clk);
    chk(issue_insns === lanes, "R9 lane positions", issue_insns, lanes);
    chk(issue_mask === 4'h3, "R3 two oldest issue", 128'(issue_mask), 128'h3);
    @(posedge clk); #1;
    drive(1'b0, 32'h0, 4'h0, 4'h3, 1'b0);
    @(negedge clk);
    chk(issue_mask === 4'h0 && grp_ready === 1'b0, "R4 no reissue",
        128'({grp_ready, issue_mask}), 128'h0);

    // R1: reset with a group still pending
    @(posedge clk); #1;
    rst_n = 1'b0;
    drive(1'b0, 32'h0, 4'h0, 4'hF, 1'b0);
    @(negedge clk);
    chk(grp_ready === 1'b1 && issue_mask === 4'h0, "R1 reset mid-group",
        128'({grp_ready, issue_mask}), 128'h10);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(grp_ready === 1'b1 && issue_mask === 4'h0, "R1 nothing after reset",
        128'({grp_ready, issue_mask}), 128'h10);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule